// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller of a small machine that issues instructions in program order but lets them complete out of order. It serves four functional units: integer, floating-point add, floating-point multiply and floating-point divide. For each unit it records whether the unit is occupied and which registers its instruction writes and reads. For each register it records whether a result is still owed to it and which unit will write it. From this state it decides, every cycle, whether the next decoded instruction may enter, which units may fetch their operands from the register file and which single unit may write its result back.

A decoded instruction is offered on `in_valid` with its unit class, destination and two source registers. It is taken on a cycle where `in_valid` and `in_ready` are both high. The functional units themselves are outside the block. A unit starts work after its read grant and reports the end of execution with a one-cycle pulse on its `done_i` bit. No result is forwarded and no register is renamed. A consumer therefore waits for the register file. A write that would destroy a value that an older instruction has not yet read is held back. A second pending write to the same register blocks entry.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After reset no unit is occupied and no register owes a result. `in_ready` is high for any offered instruction, and `rd_grant_o` and `wb_grant_o` are all low.
- R2: The unit class is encoded on `in_unit` as 0 integer, 1 FP add, 2 FP multiply and 3 FP divide. `in_ready` is low while the unit selected by `in_unit` holds an instruction that has not written back. At most one instruction is taken per cycle, in the order offered.
- R3: `in_ready` is low while `in_dst` is the destination of an accepted instruction that has not yet been granted write-back.
- R4: A unit's bit of `rd_grant_o` is high for exactly one cycle per instruction. That cycle comes no earlier than the cycle after acceptance, and only once neither source register is owed a result by another unit.
- R5: A `done_i` pulse moves a unit to result-ready only when the unit has had its read grant and has not yet completed. Pulses at any other time are ignored: no write-back grant follows from them.
- R6: A result-ready unit gets no write-back grant while another unit holds an unread source operand naming the same register as its destination.
- R7: A consumer waiting on a producer receives its read grant no earlier than the cycle after the producer's write-back grant.
- R8: At most one bit of `wb_grant_o` is high per cycle. Among eligible units, the lowest index wins.
- R9: A write-back grant frees both the unit and its destination register at the same clock edge. An instruction for that unit, or for that destination, can be accepted in the next cycle.
- R10: A source register whose producer is granted write-back in the same cycle as the consumer's acceptance counts as available. The consumer is read-granted in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_unit | input | 2 | Unit class (0 int, 1 add, 2 mul, 3 div) |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| done_i | input | 4 | Per-unit end-of-execution pulse |
| rd_grant_o | output | 4 | Per-unit operand-read grant |
| wb_grant_o | output | 4 | Per-unit write-back grant |

## Verification
All three outputs are combinational views of registered state. `in_ready` reflects the state at the edge before an offer. A read grant appears one cycle after acceptance at the earliest, or one cycle after the producer's write-back. A write-back grant appears in the cycle after the `done_i` pulse that the edge took in. The bench drives inputs just after the falling edge and compares all three outputs against its reference model shortly after. It then advances the model with those same inputs and grants, so every comparison falls in the one cycle where the result is due.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int NUM_UNITS = 4;
    localparam int UNIT_W    = $clog2(NUM_UNITS);
    localparam int NUM_REGS  = 16;
    localparam int REG_W     = $clog2(NUM_REGS);

    typedef enum logic [UNIT_W-1:0] {
        U_INT  = 2'd0,
        U_FADD = 2'd1,
        U_FMUL = 2'd2,
        U_FDIV = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPS  = 2'd1,
        PH_EXEC = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    // producer tag: which unit owes a value
    typedef struct packed {
        logic              vld;
        logic [UNIT_W-1:0] unit;
    } tag_t;

    // full per-unit record
    typedef struct packed {
        phase_e           ph;
        logic [REG_W-1:0] fi;
        logic [REG_W-1:0] fj;
        logic [REG_W-1:0] fk;
        tag_t             qj;
        tag_t             qk;
        logic             rj;
        logic             rk;
    } entry_t;

    // part of the record visible to the rest of the block
    typedef struct packed {
        phase_e           ph;
        logic [REG_W-1:0] fi;
        logic [REG_W-1:0] fj;
        logic [REG_W-1:0] fk;
        logic             rj;
        logic             rk;
    } view_t;

    function automatic logic reads_reg(view_t v, logic [REG_W-1:0] r);
        return (v.rj && v.fj == r) || (v.rk && v.fk == r);
    endfunction

endpackage

// File: rtl/sb_unit_entry.sv
module sb_unit_entry
    import sb_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_i,
    input  logic [REG_W-1:0]     dst_i,
    input  logic [REG_W-1:0]     src1_i,
    input  logic [REG_W-1:0]     src2_i,
    input  tag_t                 tag1_i,
    input  tag_t                 tag2_i,
    input  logic                 done_i,
    input  logic [NUM_UNITS-1:0] wb_gnt_i,
    output view_t                view_o,
    output logic                 rd_req_o,
    output logic                 wb_req_o
);

    entry_t ent;

    assign rd_req_o = (ent.ph == PH_OPS) && ent.rj && ent.rk;
    assign wb_req_o = (ent.ph == PH_DONE);

    assign view_o.ph = ent.ph;
    assign view_o.fi = ent.fi;
    assign view_o.fj = ent.fj;
    assign view_o.fk = ent.fk;
    assign view_o.rj = ent.rj;
    assign view_o.rk = ent.rk;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (iss_i) begin
            ent.ph <= PH_OPS;
            ent.fi <= dst_i;
            ent.fj <= src1_i;
            ent.fk <= src2_i;
            ent.qj <= tag1_i;
            ent.qk <= tag2_i;
            ent.rj <= !tag1_i.vld;
            ent.rk <= !tag2_i.vld;
        end else begin
            unique case (ent.ph)
                PH_OPS: begin
                    if (ent.rj && ent.rk) begin
                        // operands fetched this cycle
                        ent.ph <= PH_EXEC;
                        ent.rj <= 1'b0;
                        ent.rk <= 1'b0;
                    end else begin
                        if (ent.qj.vld && wb_gnt_i[ent.qj.unit]) begin
                            ent.qj.vld <= 1'b0;
                            ent.rj     <= 1'b1;
                        end
                        if (ent.qk.vld && wb_gnt_i[ent.qk.unit]) begin
                            ent.qk.vld <= 1'b0;
                            ent.rk     <= 1'b1;
                        end
                    end
                end
                PH_EXEC: if (done_i) ent.ph <= PH_DONE;
                PH_DONE: if (wb_gnt_i[IDX]) ent.ph <= PH_IDLE;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sb_reg_table.sv
module sb_reg_table
    import sb_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               set_i,
    input  logic [REG_W-1:0]                   set_reg_i,
    input  logic [UNIT_W-1:0]                  set_unit_i,
    input  logic                               clr_i,
    input  logic [REG_W-1:0]                   clr_reg_i,
    output logic [NUM_REGS-1:0]                pend_o,
    output logic [NUM_REGS-1:0][UNIT_W-1:0]    prod_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= '0;
            prod_o <= '0;
        end else begin
            if (clr_i) pend_o[clr_reg_i] <= 1'b0;
            if (set_i) begin
                pend_o[set_reg_i] <= 1'b1;
                prod_o[set_reg_i] <= set_unit_i;
            end
        end
    end

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter
    import sb_pkg::*;
(
    input  view_t [NUM_UNITS-1:0] views_i,
    output logic  [NUM_UNITS-1:0] gnt_o,
    output logic                  any_o,
    output logic  [REG_W-1:0]     dst_o
);

    logic [NUM_UNITS-1:0] blocked;
    logic [NUM_UNITS-1:0] elig;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_war
        always_comb begin
            blocked[u] = 1'b0;
            for (int g = 0; g < NUM_UNITS; g++) begin
                if (g != u && reads_reg(views_i[g], views_i[u].fi))
                    blocked[u] = 1'b1;
            end
        end
        assign elig[u] = (views_i[u].ph == PH_DONE) && !blocked[u];
    end

    always_comb begin
        gnt_o = '0;
        any_o = 1'b0;
        dst_o = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (elig[u] && !any_o) begin
                gnt_o[u] = 1'b1;
                any_o    = 1'b1;
                dst_o    = views_i[u].fi;
            end
        end
    end

endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [UNIT_W-1:0]    in_unit,
    input  logic [REG_W-1:0]     in_dst,
    input  logic [REG_W-1:0]     in_src1,
    input  logic [REG_W-1:0]     in_src2,
    input  logic [NUM_UNITS-1:0] done_i,
    output logic [NUM_UNITS-1:0] rd_grant_o,
    output logic [NUM_UNITS-1:0] wb_grant_o
);

    view_t [NUM_UNITS-1:0]              views;
    logic  [NUM_UNITS-1:0]              unit_busy;
    logic  [NUM_UNITS-1:0]              rd_req;
    logic  [NUM_UNITS-1:0]              wb_req;
    logic  [NUM_UNITS-1:0]              wb_gnt;
    logic  [NUM_REGS-1:0]               reg_pend;
    logic  [NUM_REGS-1:0][UNIT_W-1:0]   reg_prod;
    logic                               wb_any;
    logic  [REG_W-1:0]                  wb_dst;
    logic                               iss;
    tag_t                               tag1;
    tag_t                               tag2;

    assign in_ready = !unit_busy[in_unit] && !reg_pend[in_dst];
    assign iss      = in_valid && in_ready;

    // a source being written back this cycle counts as present
    assign tag1.vld  = reg_pend[in_src1] && !(wb_any && wb_dst == in_src1);
    assign tag1.unit = reg_prod[in_src1];
    assign tag2.vld  = reg_pend[in_src2] && !(wb_any && wb_dst == in_src2);
    assign tag2.unit = reg_prod[in_src2];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        sb_unit_entry #(.IDX(u)) u_ent (
            .clk      (clk),
            .rst      (rst),
            .iss_i    (iss && (in_unit == UNIT_W'(u))),
            .dst_i    (in_dst),
            .src1_i   (in_src1),
            .src2_i   (in_src2),
            .tag1_i   (tag1),
            .tag2_i   (tag2),
            .done_i   (done_i[u]),
            .wb_gnt_i (wb_gnt),
            .view_o   (views[u]),
            .rd_req_o (rd_req[u]),
            .wb_req_o (wb_req[u])
        );
        assign unit_busy[u] = (views[u].ph != PH_IDLE);
    end

    sb_reg_table u_regs (
        .clk        (clk),
        .rst        (rst),
        .set_i      (iss),
        .set_reg_i  (in_dst),
        .set_unit_i (in_unit),
        .clr_i      (wb_any),
        .clr_reg_i  (wb_dst),
        .pend_o     (reg_pend),
        .prod_o     (reg_prod)
    );

    sb_wb_arbiter u_arb (
        .views_i (views),
        .gnt_o   (wb_gnt),
        .any_o   (wb_any),
        .dst_o   (wb_dst)
    );

    assign rd_grant_o = rd_req;
    assign wb_grant_o = wb_gnt & wb_req;

endmodule

// File: rtl/sb_hazard_chk.sv
module sb_hazard_chk
    import sb_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [UNIT_W-1:0]    in_unit,
    input logic [REG_W-1:0]     in_dst,
    input logic [NUM_UNITS-1:0] busy,
    input logic [NUM_REGS-1:0]  pend,
    input logic [NUM_UNITS-1:0] rd_grant,
    input logic [NUM_UNITS-1:0] wb_grant
);

    // R8
    single_wb_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_grant));

    // R2
    busy_unit_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        busy[in_unit] |-> !in_ready);

    // R3
    pending_dst_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        pend[in_dst] |-> !in_ready);

    // R4
    rd_pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_grant & $past(rd_grant)) == '0);

    // R9
    wb_frees_unit_chk: assert property (@(posedge clk) disable iff (rst)
        (busy & $past(wb_grant)) == '0);

    // R2
    accept_occupies_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy[$past(in_unit)]);

endmodule

bind sb_hazard_ctrl sb_hazard_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_unit  (in_unit),
    .in_dst   (in_dst),
    .busy     (unit_busy),
    .pend     (reg_pend),
    .rd_grant (rd_grant_o),
    .wb_grant (wb_grant_o)
);

// File: tb/tb_sb_hazard_ctrl.sv
module tb_sb_hazard_ctrl;
    import sb_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic                 in_ready;
    logic [UNIT_W-1:0]    in_unit;
    logic [REG_W-1:0]     in_dst;
    logic [REG_W-1:0]     in_src1;
    logic [REG_W-1:0]     in_src2;
    logic [NUM_UNITS-1:0] done_i;
    logic [NUM_UNITS-1:0] rd_grant_o;
    logic [NUM_UNITS-1:0] wb_grant_o;

    always #5 clk = ~clk;

    sb_hazard_ctrl dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_unit(in_unit), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .done_i(done_i), .rd_grant_o(rd_grant_o), .wb_grant_o(wb_grant_o)
    );

    int total = 0;
    int bad   = 0;

    // instruction program
    int p_u [64];
    int p_d [64];
    int p_a [64];
    int p_b [64];
    int p_l [64];
    int np = 0;

    // behavioural model: phase 0 idle, 1 waiting operands, 2 executing, 3 result ready
    int m_ph  [NUM_UNITS];
    int m_fi  [NUM_UNITS];
    int m_fj  [NUM_UNITS];
    int m_fk  [NUM_UNITS];
    int m_qj  [NUM_UNITS];
    int m_qk  [NUM_UNITS];
    bit m_rj  [NUM_UNITS];
    bit m_rk  [NUM_UNITS];
    int m_lat [NUM_UNITS];
    int m_tmr [NUM_UNITS];
    bit m_woke[NUM_UNITS];
    bit m_cap [NUM_UNITS];
    int m_pend[NUM_REGS];
    bit freed_last;

    task automatic add(input int u, input int d, input int a, input int b, input int l);
        p_u[np] = u; p_d[np] = d; p_a[np] = a; p_b[np] = b; p_l[np] = l;
        np++;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        int ptr;
        int cyc;
        int lfsr;
        bit vld;
        int cu, cd, ca, cb;
        bit exp_ready;
        int exp_rd, exp_wb, w, ndone, nblk;
        bit blk, busy_any;
        string tag;

        // directed part: WAR, RAW, structural and WAW cases
        add(2, 2, 1, 3, 6);    // FP mul f2 (long)
        add(3, 0, 2, 4, 3);    // FP div reads f2 (RAW) and f4
        add(1, 4, 8, 10, 1);   // FP add writes f4: WAR against div
        add(2, 6, 0, 2, 2);    // second mul: structural, RAW on f0
        add(1, 4, 5, 5, 0);    // WAW on f4
        add(0, 7, 9, 9, 1);    // integer
        add(1, 11, 9, 9, 1);   // add, same latency as integer
        add(0, 12, 7, 11, 0);  // consumes both
        // pseudo-random part
        lfsr = 32'h1d2c;
        for (int i = 0; i < 44; i++) begin
            int r;
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
            r = lfsr;
            add(r % 4, (r >> 2) % 8, (r >> 5) % 8, (r >> 8) % 8, (r >> 11) % 5);
        end

        for (int u = 0; u < NUM_UNITS; u++) begin
            m_ph[u] = 0; m_rj[u] = 0; m_rk[u] = 0; m_qj[u] = -1; m_qk[u] = -1;
            m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0; m_lat[u] = 0; m_tmr[u] = 0;
            m_woke[u] = 0; m_cap[u] = 0;
        end
        for (int r = 0; r < NUM_REGS; r++) m_pend[r] = -1;
        freed_last = 0;

        rst = 1'b1; in_valid = 1'b0; in_unit = '0; in_dst = '0;
        in_src1 = '0; in_src2 = '0; done_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 ready", int'(in_ready), 1);
        chk("R1 rd_grant", int'(rd_grant_o), 0);
        chk("R1 wb_grant", int'(wb_grant_o), 0);
        @(posedge clk);

        ptr = 0;
        cyc = 0;
        busy_any = 1;
        while ((ptr < np || busy_any) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            vld = (ptr < np) && (cyc % 11 != 5);
            cu = (ptr < np) ? p_u[ptr] : 0;
            cd = (ptr < np) ? p_d[ptr] : 0;
            ca = (ptr < np) ? p_a[ptr] : 0;
            cb = (ptr < np) ? p_b[ptr] : 0;
            in_valid = vld;
            in_unit = UNIT_W'(cu);
            in_dst = REG_W'(cd);
            in_src1 = REG_W'(ca);
            in_src2 = REG_W'(cb);
            // unit stubs, plus stray pulses on units not executing (R5)
            for (int u = 0; u < NUM_UNITS; u++)
                done_i[u] = (m_ph[u] == 2 && m_tmr[u] == 0) ||
                            (m_ph[u] != 2 && (cyc % 7 == 3));
            #1;

            // expected in_ready
            exp_ready = (m_ph[cu] == 0) && (m_pend[cd] < 0);
            if (m_pend[cd] >= 0) tag = "R3 ready";
            else if (m_ph[cu] != 0) tag = "R2 ready";
            else if (freed_last) tag = "R9 ready";
            else tag = "R2 ready";
            chk(tag, int'(in_ready), int'(exp_ready));

            // expected read grants
            exp_rd = 0;
            tag = "R4 rd_grant";
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (m_ph[u] == 1 && m_rj[u] && m_rk[u]) begin
                    exp_rd |= (1 << u);
                    if (m_woke[u]) tag = "R7 rd_grant";
                    if (m_cap[u]) tag = "R10 rd_grant";
                end
            end
            chk(tag, int'(rd_grant_o), exp_rd);

            // expected write-back grant
            w = -1; ndone = 0; nblk = 0;
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (m_ph[u] == 3) begin
                    ndone++;
                    blk = 0;
                    for (int g = 0; g < NUM_UNITS; g++)
                        if (g != u && ((m_rj[g] && m_fj[g] == m_fi[u]) ||
                                       (m_rk[g] && m_fk[g] == m_fi[u])))
                            blk = 1;
                    if (blk) nblk++;
                    else if (w < 0) w = u;
                end
            end
            exp_wb = (w >= 0) ? (1 << w) : 0;
            if (nblk > 0) tag = "R6 wb_grant";
            else if (ndone > 1) tag = "R8 wb_grant";
            else tag = "R5 wb_grant";
            chk(tag, int'(wb_grant_o), exp_wb);

            // advance the model to the next edge
            freed_last = (w >= 0);
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (m_ph[u] == 2) begin
                    if (done_i[u]) m_ph[u] = 3;
                    else m_tmr[u]--;
                end
            end
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (exp_rd[u]) begin
                    m_ph[u] = 2; m_rj[u] = 0; m_rk[u] = 0;
                    m_tmr[u] = m_lat[u]; m_woke[u] = 0; m_cap[u] = 0;
                end
            end
            if (vld && exp_ready) begin
                int pj, pk;
                pj = m_pend[ca];
                pk = m_pend[cb];
                if (w >= 0 && m_fi[w] == ca) pj = -1;
                if (w >= 0 && m_fi[w] == cb) pk = -1;
                m_ph[cu] = 1; m_fi[cu] = cd; m_fj[cu] = ca; m_fk[cu] = cb;
                m_qj[cu] = pj; m_qk[cu] = pk;
                m_rj[cu] = (pj < 0); m_rk[cu] = (pk < 0);
                m_lat[cu] = p_l[ptr];
                m_woke[cu] = 0;
                m_cap[cu] = (w >= 0) && ((m_pend[ca] == w) || (m_pend[cb] == w));
            end
            if (w >= 0) begin
                m_ph[w] = 0;
                m_pend[m_fi[w]] = -1;
                for (int g = 0; g < NUM_UNITS; g++) begin
                    if (m_ph[g] == 1 && !(vld && exp_ready && g == cu)) begin
                        if (m_qj[g] == w) begin m_qj[g] = -1; m_rj[g] = 1; m_woke[g] = 1; end
                        if (m_qk[g] == w) begin m_qk[g] = -1; m_rk[g] = 1; m_woke[g] = 1; end
                    end
                end
            end
            if (vld && exp_ready) begin
                m_pend[cd] = cu;
                ptr++;
            end
            busy_any = 0;
            for (int u = 0; u < NUM_UNITS; u++) if (m_ph[u] != 0) busy_any = 1;
        end

        if (cyc >= 5000) begin
            total++;
            bad++;
            $display("FAIL watchdog: R2 stream stalled actual=%0d expected=%0d", ptr, np);
        end

        // drained: back to the reset-like state (R1, R9)
        @(negedge clk);
        in_valid = 1'b0; done_i = '0;
        #1;
        chk("R9 drained ready", int'(in_ready), 1);
        chk("R1 drained rd_grant", int'(rd_grant_o), 0);
        chk("R1 drained wb_grant", int'(wb_grant_o), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule